// File: doc/BRIEF.md
# Keyed Nibble Substitution-Permutation Round

This block applies one keyed round of a small 16-bit substitution-permutation cipher. The incoming word is first XORed with a 16-bit subkey. The keyed word is then cut into four nibbles, and each nibble goes through its own fixed 4-bit substitution box. The box outputs are folded into a running 4-bit XOR chain whose starting value is the top nibble of the keyed word. The bits of every chain value are spread over the four output nibbles. The assembled word is XORed with the same subkey once more and then leaves the block.

Words enter on a valid/ready stream and leave on another through a single register stage. A word is accepted on a clock edge where `in_valid` and `in_ready` are both high. The stage can accept a new word when it is empty or when its current word is being taken on the same edge, so `in_ready = !out_valid || out_ready`. When `out_valid` is high and `out_ready` is low, the output word and `out_valid` stay fixed and no input is accepted. Between accepted words the output register keeps its last value.

Top module: `spn_round`

## Requirements
- R1: `out_result` equals T(`in_data` ^ `in_key`) ^ `in_key`. T is the unkeyed transform defined in R2 to R5, and the same subkey is used on both sides of it.
- R2: T splits its input into nibbles n0 (bits 3:0) through n3 (bits 15:12). A running 4-bit value c starts at n3. For step j = 0, 1, 2, 3, taken in that order, c becomes c ^ Sj(nj).
- R3: After step j updates c, bit i of c (i = 0..3) is written to bit i of output nibble (j − i) mod 4. Each output bit therefore comes from exactly one step.
- R4: The four boxes map inputs 0..15 as follows. S0: 9,8,2,11,1,14,5,15,12,6,0,3,7,13,10,4. S1: 2,10,0,15,14,1,11,3,7,12,13,8,4,9,5,6. S2: 4,11,3,8,7,2,15,13,1,5,14,9,6,12,0,10. S3: 1,13,8,2,0,5,6,14,4,11,15,10,12,3,7,9.
- R5: Output nibble k of T occupies bits 4k+3:4k. With a zero word and a zero key, the result is 16'h8BFF. With a zero word and key 16'hFFFF, the result is 16'h9402.
- R6: After a word is accepted, `out_valid` is high and `out_result` holds that word's result from the next clock edge on.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_result` stays unchanged. An offered input word is not accepted during this time.
- R8: `in_ready` is high whenever `out_valid` is low or `out_ready` is high, and low otherwise.
- R9: After `rst_n` is asserted low, `out_valid` is 0 and `out_result` is 16'h0000.
- R10: On an edge where no word is accepted, `out_result` keeps its value. If `out_ready` was high on that edge, `out_valid` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Stage can take a word this cycle |
| in_data | input | 16 | Word to transform |
| in_key | input | 16 | Subkey for this word |
| out_valid | output | 1 | Result word present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 16 | Transformed word |

## Verification
The round is exercised with several kinds of input. Two hand-computed anchors (an all-zero word with key zero and with key all-ones) pin the absolute box contents and the bit routing. Words with a single non-zero nibble separate the four boxes from each other, and single-bit words show which output nibble each chain step reaches. Equal data and key values cancel the whitening at the input but not at the output, which shows that the key is applied twice. Separately, the stream side is driven with back-pressure, with back-to-back words and with idle cycles, so that holding, acceptance and the ready rule can each be observed alone.

// File: rtl/spn_round_pkg.sv
package spn_round_pkg;
  localparam int unsigned NIB_W  = 4;
  localparam int unsigned NIB_N  = 4;
  localparam int unsigned WORD_W = NIB_W * NIB_N;

  // Box k, entry x is bits 4x+3:4x of row k.
  localparam logic [NIB_N-1:0][63:0] SBOX_ROWS = {
    64'h973C_AFB4_E650_28D1,
    64'hA0C6_9E51_DF27_83B4,
    64'h6594_8DC7_3B1E_F0A2,
    64'h4AD7_306C_F5E1_B289
  };

  typedef logic [NIB_W-1:0]             nib_t;
  typedef logic [NIB_N-1:0][NIB_W-1:0]  word_nibs_t;

  function automatic nib_t sbox_lookup(input int unsigned box, input nib_t x);
    logic [63:0] row;
    row = SBOX_ROWS[box];
    return row[x*NIB_W +: NIB_W];
  endfunction
endpackage

// File: rtl/spn_sbox_layer.sv
module spn_sbox_layer
  import spn_round_pkg::*;
(
  input  word_nibs_t nibs_in,
  output word_nibs_t nibs_out
);
  for (genvar g = 0; g < NIB_N; g++) begin : g_box
    always_comb nibs_out[g] = sbox_lookup(g, nibs_in[g]);
  end
endmodule

// File: rtl/spn_diffuse.sv
module spn_diffuse
  import spn_round_pkg::*;
(
  input  nib_t       seed,
  input  word_nibs_t subst,
  output word_nibs_t mixed
);
  word_nibs_t chain;

  // running XOR chain, step j folds in box j
  for (genvar j = 0; j < NIB_N; j++) begin : g_chain
    if (j == 0) begin : g_first
      always_comb chain[j] = seed ^ subst[j];
    end else begin : g_next
      always_comb chain[j] = chain[j-1] ^ subst[j];
    end
  end

  // bit b of output nibble k comes from step (k + b) mod NIB_N
  for (genvar k = 0; k < NIB_N; k++) begin : g_onib
    for (genvar b = 0; b < NIB_W; b++) begin : g_obit
      localparam int unsigned SRC = (k + b) % NIB_N;
      always_comb mixed[k][b] = chain[SRC][b];
    end
  end
endmodule

// File: rtl/spn_round_core.sv
module spn_round_core
  import spn_round_pkg::*;
(
  input  logic [WORD_W-1:0] data,
  input  logic [WORD_W-1:0] key,
  output logic [WORD_W-1:0] result
);
  word_nibs_t keyed;
  word_nibs_t subst;
  word_nibs_t mixed;

  always_comb keyed = word_nibs_t'(data ^ key);

  spn_sbox_layer u_boxes (
    .nibs_in  (keyed),
    .nibs_out (subst)
  );

  spn_diffuse u_mix (
    .seed  (keyed[NIB_N-1]),
    .subst (subst),
    .mixed (mixed)
  );

  always_comb result = WORD_W'(mixed) ^ key;
endmodule

// File: rtl/spn_pipe_stage.sv
module spn_pipe_stage #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);
  logic take;

  always_comb up_ready = !dn_valid || dn_ready;
  always_comb take     = up_valid && up_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dn_valid <= 1'b0;
      dn_data  <= '0;
    end else begin
      if (up_ready) dn_valid <= up_valid;
      if (take)     dn_data  <= up_data;
    end
  end
endmodule

// File: rtl/spn_round.sv
module spn_round
  import spn_round_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic [WORD_W-1:0] in_key,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_result
);
  logic [WORD_W-1:0] comb_result;

  spn_round_core u_core (
    .data   (in_data),
    .key    (in_key),
    .result (comb_result)
  );

  spn_pipe_stage #(.W(WORD_W)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (comb_result),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (out_result)
  );
endmodule

// File: rtl/spn_round_chk.sv
module spn_round_chk
  import spn_round_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_result
);
  // R6
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result)));

  // R8
  ready_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid || out_ready) |-> in_ready);

  // R8
  stall_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(out_result));
endmodule

bind spn_round spn_round_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result)
);

// File: tb/spn_round_tb.sv
module spn_round_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;

  // data, key, expected (16'hxxxx-free; expected 0 -> use model)
  typedef struct packed {
    logic [15:0] d;
    logic [15:0] k;
    logic        hand;
    logic [15:0] e;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{16'h0000, 16'h0000, 1'b1, 16'h8BFF},
    '{16'h0000, 16'hFFFF, 1'b1, 16'h9402},
    '{16'h000F, 16'h0000, 1'b0, 16'h0000},
    '{16'h00F0, 16'h0000, 1'b0, 16'h0000},
    '{16'h0F00, 16'h0000, 1'b0, 16'h0000},
    '{16'hF000, 16'h0000, 1'b0, 16'h0000},
    '{16'h1234, 16'h1234, 1'b0, 16'h0000},
    '{16'hA5C3, 16'h3C5A, 1'b0, 16'h0000},
    '{16'h0001, 16'h8000, 1'b0, 16'h0000},
    '{16'hFFFF, 16'h0F0F, 1'b0, 16'h0000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic [15:0] in_key = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_result;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spn_round u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_key(in_key), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result)
  );

  int sb0 [16] = '{9,8,2,11,1,14,5,15,12,6,0,3,7,13,10,4};
  int sb1 [16] = '{2,10,0,15,14,1,11,3,7,12,13,8,4,9,5,6};
  int sb2 [16] = '{4,11,3,8,7,2,15,13,1,5,14,9,6,12,0,10};
  int sb3 [16] = '{1,13,8,2,0,5,6,14,4,11,15,10,12,3,7,9};

  function automatic int box(int j, int x);
    case (j)
      0: return sb0[x];
      1: return sb1[x];
      2: return sb2[x];
      default: return sb3[x];
    endcase
  endfunction

  function automatic logic [15:0] model(logic [15:0] d, logic [15:0] k);
    logic [15:0] x;
    logic [15:0] o;
    int c;
    x = d ^ k;
    o = '0;
    c = int'(x[15:12]);
    for (int j = 0; j < 4; j++) begin
      c = c ^ box(j, int'((x >> (4*j)) & 16'hF));
      for (int i = 0; i < 4; i++)
        if ((c >> i) & 1) o[4*((j - i + 4) % 4) + i] = 1'b1;
    end
    return o ^ k;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // offer a word, wait one edge, sample just after it
  task automatic push(logic [15:0] d, logic [15:0] k, logic rdy);
    @(negedge clk);
    in_valid  = 1'b1;
    in_data   = d;
    in_key    = k;
    out_ready = rdy;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    repeat (3) @(posedge clk);
    #1;
    // R9 reset state
    check("R9 valid", {15'd0, out_valid}, 16'd0);
    check("R9 result", out_result, 16'h0000);
    check("R8 ready when empty", {15'd0, in_ready}, 16'd1);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 R2 R3 R4 R5 R6: vector table
    for (int v = 0; v < NVEC; v++) begin
      logic [15:0] exp;
      exp = VECS[v].hand ? VECS[v].e : model(VECS[v].d, VECS[v].k);
      push(VECS[v].d, VECS[v].k, 1'b1);
      check("R6 valid after accept", {15'd0, out_valid}, 16'd1);
      check("R1 R2 R3 R4 R5 result", out_result, exp);
    end

    // R4: sweep every box entry via single-nibble words
    for (int j = 0; j < 4; j++) begin
      for (int x = 0; x < 16; x++) begin
        logic [15:0] d;
        d = 16'(x) << (4*j);
        push(d, 16'h0000, 1'b1);
        check("R4 box sweep", out_result, model(d, 16'h0000));
      end
    end

    // R3: single-bit words and keys
    for (int b = 0; b < 16; b++) begin
      push(16'h0001 << b, 16'h5A5A, 1'b1);
      check("R3 bit routing", out_result, model(16'h0001 << b, 16'h5A5A));
    end

    // R10: idle cycle, result holds, valid drops
    held = out_result;
    @(negedge clk);
    in_valid = 1'b0;
    in_data = 16'hDEAD;
    in_key = 16'hBEEF;
    out_ready = 1'b1;
    @(posedge clk);
    #1;
    check("R10 result held idle", out_result, held);
    check("R10 valid dropped", {15'd0, out_valid}, 16'd0);

    // R7 R8: back-pressure
    push(16'h1111, 16'h2222, 1'b0);
    held = out_result;
    check("R6 stalled accept", held, model(16'h1111, 16'h2222));
    check("R8 not ready while stalled", {15'd0, in_ready}, 16'd0);
    push(16'h3333, 16'h4444, 1'b0);
    check("R7 result held stalled", out_result, held);
    check("R7 valid held stalled", {15'd0, out_valid}, 16'd1);
    // release: in_ready high again, new word taken
    @(negedge clk);
    out_ready = 1'b1;
    #1;
    check("R8 ready when drained", {15'd0, in_ready}, 16'd1);
    @(posedge clk);
    #1;
    check("R7 word taken after release", out_result, model(16'h3333, 16'h4444));

    // R9: reset mid-stream
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R9 valid on reset", {15'd0, out_valid}, 16'd0);
    check("R9 result on reset", out_result, 16'h0000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule